// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with High and Low Result Registers

This block is a multi-cycle arithmetic unit for 32-bit integer multiplication and division. A one-cycle start pulse supplies an operation code and two operands, a first (`rs_i`) and a second (`rt_i`). The unit loads the operand magnitudes and runs one step per cycle: shift-and-add for a product, restoring subtract-and-shift for a quotient. A final cycle then restores the signs and writes the two result registers.

A product fills both registers. The high register gets the upper half and the low register gets the lower half. A division puts the quotient in the low register and the remainder in the high register. The unit does both operations in two's-complement and unsigned forms. The results are visible only on the two read outputs, which keep their value until the next operation completes. While `busy_o` is high the unit refuses new work, and `done_o` pulses once when fresh results are present.

Top module: `muldiv_unit`

## Requirements
- R1: A start pulse seen while the unit is idle is accepted: `busy_o` is high from the next cycle.
- R2: After acceptance `busy_o` stays high for exactly WIDTH+1 cycles (32 iteration cycles plus one sign-correction cycle), for every operation and operand value.
- R3: In the first cycle with `busy_o` low again, `hi_o`/`lo_o` hold the new results and `done_o` is high for that single cycle.
- R4: `hi_o` and `lo_o` change only in a cycle where `done_o` is high. They hold their value during an operation and while idle.
- R5: A start pulse while `busy_o` is high is ignored. The running operation's results, timing and operands are unchanged.
- R6: Operation code 1 (unsigned multiply; bit 1 = 0 selects multiply, bit 0 = 1 selects unsigned) gives the 64-bit unsigned product, with the upper 32 bits on `hi_o` and the lower 32 bits on `lo_o`.
- R7: Operation code 0 (signed multiply) treats both operands as two's complement and gives the 64-bit two's-complement product, split as in R6.
- R8: Operation code 3 (unsigned divide) divides `rs_i` by `rt_i` as unsigned values, with the quotient on `lo_o` and the remainder on `hi_o`.
- R9: Operation code 2 (signed divide) divides `rs_i` by `rt_i` as two's-complement values. The quotient truncates toward zero and the nonzero remainder has the sign of the dividend. The most-negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R10: A divide by zero still finishes within the R2 timing and pulses `done_o`. The result values are unspecified.
- R11: After reset `hi_o` and `lo_o` are zero and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: bit 1 divide, bit 0 unsigned |
| rs_i | input | 32 | First operand (multiplicand or dividend) |
| rt_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when new results are written |
| hi_o | output | 32 | High result register: upper product half or remainder |
| lo_o | output | 32 | Low result register: lower product half or quotient |

## Verification
The bench goes after several corner cases, each tied to a distinct failure:
- **Sign-correction cases.** These are negative times positive, negative divided by negative, and a negative dividend with a positive divisor. A design that applies the quotient sign to the remainder, or negates only one half of the product, returns wrong high or low words here.
- **Extreme operands.** The most-negative operand, all-ones unsigned operands, and the most-negative value divided by -1 expose magnitude overflow and a missing carry into the upper half.
- **Divide by zero.** This is run to show that the iteration count does not depend on operand values. A design whose step count is off by one shows it as a wrong `busy_o` length.
- **Start during an operation.** A start pulse during a running operation is driven with different operands. A design that re-latches returns the second operation's result or restarts the busy window.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // bit 1: divide, bit 0: unsigned
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } md_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIX  = 2'd2
  } md_phase_e;
endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] rs_i,
  input  logic [WIDTH-1:0] rt_i,
  output logic [WIDTH-1:0] mag_a_o,
  output logic [WIDTH-1:0] mag_b_o,
  output logic             is_div_o,
  output logic             neg_lo_o,
  output logic             neg_hi_o
);
  logic is_signed, neg_a, neg_b;

  always_comb begin
    is_signed = ~op_i[0];
    is_div_o  = op_i[1];
    neg_a     = is_signed & rs_i[WIDTH-1];
    neg_b     = is_signed & rt_i[WIDTH-1];
    mag_a_o   = neg_a ? (~rs_i + 1'b1) : rs_i;
    mag_b_o   = neg_b ? (~rt_i + 1'b1) : rt_i;
    // product: both halves share a sign; divide: remainder follows dividend
    neg_lo_o  = neg_a ^ neg_b;
    neg_hi_o  = is_div_o ? neg_a : (neg_a ^ neg_b);
  end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic [WIDTH-1:0] acc_hi_i,
  input  logic [WIDTH-1:0] acc_lo_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] acc_hi_o,
  output logic [WIDTH-1:0] acc_lo_o
);
  logic [WIDTH:0]   add_sum;
  logic [WIDTH:0]   rem_sh;
  logic [WIDTH+1:0] trial;
  logic             fits;

  always_comb begin
    // shift-add: add multiplicand on lsb, shift the pair right
    add_sum = {1'b0, acc_hi_i} + (acc_lo_i[0] ? {1'b0, opb_i} : '0);
    // restoring: shift pair left, trial subtract divisor
    rem_sh  = {acc_hi_i, acc_lo_i[WIDTH-1]};
    trial   = {1'b0, rem_sh} - {2'b00, opb_i};
    fits    = ~trial[WIDTH+1];
    if (is_div_i) begin
      acc_hi_o = fits ? trial[WIDTH-1:0] : rem_sh[WIDTH-1:0];
      acc_lo_o = {acc_lo_i[WIDTH-2:0], fits};
    end else begin
      acc_hi_o = add_sum[WIDTH:1];
      acc_lo_o = {add_sum[0], acc_lo_i[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  md_phase_e       phase_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;

  always_comb begin
    load_o = (phase_q == PH_IDLE) && start_i;
    step_o = (phase_q == PH_RUN);
    fix_o  = (phase_q == PH_FIX);
    busy_o = (phase_q != PH_IDLE);
    done_o = done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
        end
        PH_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) phase_q <= PH_FIX;
        end
        PH_FIX: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] rs_i,
  input  logic [WIDTH-1:0] rt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int PW = 2 * WIDTH;

  logic             load, step, fix;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic             is_div, neg_lo, neg_hi;
  logic [WIDTH-1:0] acc_hi_q, acc_lo_q, opb_q;
  logic [WIDTH-1:0] nxt_hi, nxt_lo;
  logic             is_div_q, neg_lo_q, neg_hi_q;
  logic [WIDTH-1:0] hi_q, lo_q;
  logic [PW-1:0]    prod_neg;

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fix_o  (fix),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  muldiv_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i    (op_i),
    .rs_i    (rs_i),
    .rt_i    (rt_i),
    .mag_a_o (mag_a),
    .mag_b_o (mag_b),
    .is_div_o(is_div),
    .neg_lo_o(neg_lo),
    .neg_hi_o(neg_hi)
  );

  muldiv_step #(.WIDTH(WIDTH)) u_step (
    .is_div_i(is_div_q),
    .acc_hi_i(acc_hi_q),
    .acc_lo_i(acc_lo_q),
    .opb_i   (opb_q),
    .acc_hi_o(nxt_hi),
    .acc_lo_o(nxt_lo)
  );

  assign prod_neg = ~{acc_hi_q, acc_lo_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_hi_q <= '0;
      acc_lo_q <= '0;
      opb_q    <= '0;
      is_div_q <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
    end else if (load) begin
      acc_hi_q <= '0;
      acc_lo_q <= mag_a;
      opb_q    <= mag_b;
      is_div_q <= is_div;
      neg_lo_q <= neg_lo;
      neg_hi_q <= neg_hi;
    end else if (step) begin
      acc_hi_q <= nxt_hi;
      acc_lo_q <= nxt_lo;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fix) begin
      if (is_div_q) begin
        lo_q <= neg_lo_q ? (~acc_lo_q + 1'b1) : acc_lo_q;
        hi_q <= neg_hi_q ? (~acc_hi_q + 1'b1) : acc_hi_q;
      end else if (neg_lo_q) begin
        hi_q <= prod_neg[PW-1:WIDTH];
        lo_q <= prod_neg[WIDTH-1:0];
      end else begin
        hi_q <= acc_hi_q;
        lo_q <= acc_lo_q;
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/muldiv_checks.sv
module muldiv_checks #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);
  localparam int LW = $clog2(WIDTH) + 3;

  logic [LW-1:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  assert_start_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len == LW'(WIDTH + 1)));

  assert_done_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_results_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hi_o) || !$stable(lo_o)) |-> done_o);

  assert_restart_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && busy_len < LW'(WIDTH)) |=> (busy_o && busy_len != '0));
endmodule

bind muldiv_unit muldiv_checks #(.WIDTH(WIDTH)) u_checks (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .hi_o   (hi_o),
  .lo_o   (lo_o)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] rs = '0, rt = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  muldiv_unit #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .rs_i(rs), .rt_i(rt), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'd0: p = 64'(sa * sb);
      2'd1: p = {32'd0, a} * {32'd0, b};
      2'd2: begin
        q = sa / sb; r = sa % sb;
        p = {r[31:0], q[31:0]};
      end
      default: p = {a % b, a / b};
    endcase
    return p;
  endfunction

  function automatic string tag_of(input logic [1:0] o);
    case (o)
      2'd0: return "R7";
      2'd1: return "R6";
      2'd2: return "R9";
      default: return "R8";
    endcase
  endfunction

  // issue one op; optionally poke a second start mid-run; returns results and busy length
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input bit poke, output logic [63:0] res, output int blen);
    int guard;
    @(negedge clk);
    start = 1'b1; op = o; rs = a; rt = b;
    @(negedge clk);
    start = 1'b0;
    blen = 0; guard = 0;
    while (busy && guard < 200) begin
      blen++; guard++;
      if (poke && blen == 5) begin
        start = 1'b1; op = ~o; rs = ~a; rt = b ^ 32'h5a5a_0001;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (guard >= 200) begin
      failures++; checks++;
      $display("FAIL R2 busy never dropped act=%0d exp=%0d", guard, W + 1);
    end
    checks++;
    if (!done) begin
      failures++;
      $display("FAIL R3 done act=%b exp=1", done);
    end
    res = {hi, lo};
    @(negedge clk);
    check("R3 done single", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] res, exp;
    int blen;
    logic [31:0] a, b;
    logic [1:0] o;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 hi", {32'd0, hi}, 64'd0);
    check("R11 lo", {32'd0, lo}, 64'd0);
    check("R11 busy/done", {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 acceptance: busy visible one cycle after start
    start = 1'b1; op = 2'd1; rs = 32'd3; rt = 32'd4;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", {63'd0, busy}, 64'd1);
    check("R4 hold during run", {hi, lo}, 64'd0);
    while (busy) @(negedge clk);
    check("R6 3*4", {hi, lo}, 64'd12);

    // directed corners
    begin
      logic [1:0]  dop [10] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd3, 2'd0, 2'd3};
      logic [31:0] da  [10] = '{32'hffff_fff9, 32'h8000_0000, 32'hffff_ffff, 32'hffff_fff9,
                                32'hffff_fff9, 32'h8000_0000, 32'd7, 32'hffff_ffff,
                                32'h8000_0000, 32'd5};
      logic [31:0] db  [10] = '{32'd3, 32'h8000_0000, 32'hffff_ffff, 32'd2,
                                32'hffff_fffe, 32'hffff_ffff, 32'hffff_fffe, 32'd1,
                                32'd1, 32'd9};
      for (int i = 0; i < 10; i++) begin
        run_op(dop[i], da[i], db[i], 1'b0, res, blen);
        check(tag_of(dop[i]), res, model(dop[i], da[i], db[i]));
        check("R2 busy length", 64'(blen), 64'(W + 1));
      end
    end

    // R10 divide by zero terminates on time
    run_op(2'd3, 32'h1234_5678, 32'd0, 1'b0, res, blen);
    check("R10 div0 unsigned length", 64'(blen), 64'(W + 1));
    run_op(2'd2, 32'h8765_4321, 32'd0, 1'b0, res, blen);
    check("R10 div0 signed length", 64'(blen), 64'(W + 1));

    // R5 start while busy ignored
    run_op(2'd0, 32'hfff0_0003, 32'd12345, 1'b1, res, blen);
    check("R5 result unchanged", res, model(2'd0, 32'hfff0_0003, 32'd12345));
    check("R5 length unchanged", 64'(blen), 64'(W + 1));
    run_op(2'd2, 32'h8000_0011, 32'd77, 1'b1, res, blen);
    check("R5 div result unchanged", res, model(2'd2, 32'h8000_0011, 32'd77));

    // R4 results hold while idle
    exp = {hi, lo};
    rs = 32'hdead_beef; rt = 32'h1; op = 2'd1;
    repeat (4) @(negedge clk);
    check("R4 idle hold", {hi, lo}, exp);

    // random mix
    for (int n = 0; n < 160; n++) begin
      o = 2'($urandom_range(0, 3));
      a = $urandom();
      b = $urandom();
      if ($urandom_range(0, 3) == 0) b = b >> $urandom_range(8, 31);
      if ($urandom_range(0, 3) == 0) a = a >> $urandom_range(8, 31);
      if (o[1] && b == 32'd0) b = 32'd1;
      run_op(o, a, b, 1'b0, res, blen);
      check(tag_of(o), res, model(o, a, b));
      check("R2 busy length", 64'(blen), 64'(W + 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule